// File: doc/BRIEF.md
# Interleaved Processor/Video DRAM Slot Arbiter

This block lets a processor and a video fetcher share a single dynamic RAM. Time is cut into slots of a fixed number of sub-clocks. Each slot carries exactly one full RAS/CAS cycle, whoever owns it. The strobe rate therefore never changes, even when the processor switches between its normal and fast speed settings.

In the normal setting, slots alternate between the processor and the video side. Every video slot fetches one word and steps the video address counter. The low counter bits form the DRAM row, so the video sweep also refreshes every row. In the fast setting, every slot goes to the processor. Video fetches stop, and with them the refresh, and the counter stays frozen.

A processor access that decodes to ROM still runs a complete strobe cycle. That dummy read keeps the data-out gate closed, so the RAM data never reaches the processor bus.

Top module: `dram_slot_arbiter`

## Requirements
- R1: Every slot lasts SLOT_LEN (default 8) clocks in both speed settings. Offsets within a slot are counted from 0. RAS_n is low at offsets 1..5 and CAS_n is low at offsets 3..5. Both strobes are high at all other offsets.
- R2: When fast_mode_i is low at a slot boundary, the next slot goes to the other owner. Starting from reset, this gives processor, video, processor, video.
- R3: When fast_mode_i is high at a slot boundary, the next slot goes to the processor. While the fast setting lasts, vid_grant_o stays low.
- R4: Refresh follows the video fetch. Successive video slots present rows that step by one, modulo 2^ROW_W. In the fast setting, no video RAS cycle occurs and vid_addr_o does not change.
- R5: dram_addr_o carries the row, which is the slot address bits [ROW_W-1:0], at offsets 0 and 1. It carries the column, which is bits [2*ROW_W-1:ROW_W], from offset 2 onward. The bus therefore switches one clock after RAS falls and one clock before CAS falls.
- R6: fast_mode_i and the processor inputs are sampled only on the clock edge that ends a slot. Changing them in the middle of a slot leaves the owner, grants and address of the current slot unchanged.
- R7: A processor slot with cpu_ram_sel_i low (ROM) still runs the full strobe cycle of R1. In such a slot ram_oe_o stays low and dram_we_n_o stays high.
- R8: ram_oe_o is high at offsets 3..5 only in processor slots that are RAM reads (cpu_ram_sel_i=1, cpu_rd_i=1). dram_we_n_o is low at offsets 3..5 only in processor RAM writes (cpu_rd_i=0).
- R9: In a video slot, vid_valid_o pulses high for exactly one clock at offset 6. At that time vid_data_o holds the DRAM word at the slot's video address, and vid_addr_o has already advanced by one.
- R10: During reset and at offset 0 of the first slot afterwards, the outputs are as follows. Both strobes are high, cpu_grant_o is 1, vid_grant_o is 0, ram_oe_o is 0 and vid_addr_o is 0. The first slot belongs to the processor, with address 0 decoded as ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode_i | input | 1 | Speed setting: 1 gives every slot to the processor |
| cpu_addr_i | input | 2*ROW_W | Processor word address |
| cpu_rd_i | input | 1 | 1 = read, 0 = write |
| cpu_ram_sel_i | input | 1 | 1 = address decodes to RAM, 0 = ROM |
| dram_dq_i | input | DW | Data returned by the DRAM |
| dram_addr_o | output | ROW_W | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| ram_oe_o | output | 1 | Gate for RAM data onto the processor bus |
| cpu_grant_o | output | 1 | Current slot belongs to the processor |
| vid_grant_o | output | 1 | Current slot belongs to the video fetcher |
| vid_addr_o | output | 2*ROW_W | Video address counter |
| vid_data_o | output | DW | Last fetched video word |
| vid_valid_o | output | 1 | One-clock strobe for vid_data_o |

## Verification
The assertions assume two things about the inputs:
- fast_mode_i and the processor inputs are settled before the slot-ending edge.
- The DRAM drives valid data for as long as CAS_n is low.

The bench changes the processor inputs and the speed setting in mid-slot, away from the boundary. It also flips fast_mode_i to the wrong value earlier in each slot, so that any sampling outside the boundary becomes visible.

Its memory model latches the row on the falling edge of RAS_n. It returns a word computed from the address only while CAS_n is low, so a wrong row/column order or a wrong capture time shows up as bad video data.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_VID = 1'b1
  } owner_e;

  typedef struct packed {
    owner_e own;
    logic   rd;
    logic   ram;
  } slot_ctx_t;

  localparam slot_ctx_t CTX_RESET = '{own: OWN_CPU, rd: 1'b1, ram: 1'b0};

endpackage

// File: rtl/dsa_phase_ctr.sv
module dsa_phase_ctr #(
  parameter int SLOT_LEN = 8,
  localparam int PH_W = $clog2(SLOT_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_nxt,
  output logic            last
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_LEN - 1);

  assign last   = (ph_q == LAST_PH);
  assign ph_nxt = last ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_nxt;
  end

  // R1: the phase wraps to offset 0 right after the last offset
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    last |=> (ph_q == '0));

endmodule

// File: rtl/dsa_owner_sel.sv
module dsa_owner_sel
  import dram_slot_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            last,
  input  logic            fast_mode_i,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic            cpu_rd_i,
  input  logic            cpu_ram_sel_i,
  input  logic [AW-1:0]   vid_addr_i,
  output slot_ctx_t       ctx_q,
  output slot_ctx_t       ctx_nxt,
  output logic [AW-1:0]   addr_nxt
);

  logic [AW-1:0] addr_q;
  owner_e        own_pick;

  always_comb begin
    if (fast_mode_i)               own_pick = OWN_CPU;
    else if (ctx_q.own == OWN_CPU) own_pick = OWN_VID;
    else                           own_pick = OWN_CPU;
  end

  always_comb begin
    ctx_nxt  = ctx_q;
    addr_nxt = addr_q;
    if (last) begin
      ctx_nxt.own = own_pick;
      ctx_nxt.rd  = cpu_rd_i;
      ctx_nxt.ram = cpu_ram_sel_i;
      addr_nxt    = (own_pick == OWN_CPU) ? cpu_addr_i : vid_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q  <= CTX_RESET;
      addr_q <= '0;
    end else begin
      ctx_q  <= ctx_nxt;
      addr_q <= addr_nxt;
    end
  end

  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    (last && !fast_mode_i) |=> (ctx_q.own != $past(ctx_q.own)));

  a_r3_fast_cpu: assert property (@(posedge clk) disable iff (rst)
    (last && fast_mode_i) |=> (ctx_q.own == OWN_CPU));

  a_r6_hold_mid_slot: assert property (@(posedge clk) disable iff (rst)
    !last |=> ($stable(ctx_q) && $stable(addr_q)));

endmodule

// File: rtl/dsa_video_fetch.sv
module dsa_video_fetch #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] vid_addr_o,
  output logic [DW-1:0] vid_data_o,
  output logic          vid_valid_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_addr_o  <= '0;
      vid_data_o  <= '0;
      vid_valid_o <= 1'b0;
    end else begin
      vid_valid_o <= cap;
      if (cap) begin
        vid_data_o <= dq_i;
        vid_addr_o <= vid_addr_o + 1'b1;
      end
    end
  end

  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    vid_valid_o |-> (vid_addr_o == $past(vid_addr_o) + 1'b1));

  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    !vid_valid_o |-> (vid_addr_o == $past(vid_addr_o)));

endmodule

// File: rtl/dsa_strobe_drv.sv
module dsa_strobe_drv
  import dram_slot_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int PH_W   = 3,
  parameter int RAS_PH = 1,
  parameter int COL_PH = 2,
  parameter int CAS_PH = 3,
  parameter int PRE_PH = 6,
  localparam int AW = 2 * ROW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph_nxt,
  input  slot_ctx_t        ctx_nxt,
  input  logic [AW-1:0]    addr_nxt,
  output logic [ROW_W-1:0] dram_addr_o,
  output logic             dram_ras_n_o,
  output logic             dram_cas_n_o,
  output logic             dram_we_n_o,
  output logic             ram_oe_o,
  output logic             cpu_grant_o,
  output logic             vid_grant_o
);

  logic in_ras, in_cas, use_col, cpu_ram;

  assign in_ras  = (ph_nxt >= PH_W'(RAS_PH)) && (ph_nxt < PH_W'(PRE_PH));
  assign in_cas  = (ph_nxt >= PH_W'(CAS_PH)) && (ph_nxt < PH_W'(PRE_PH));
  assign use_col = (ph_nxt >= PH_W'(COL_PH));
  assign cpu_ram = (ctx_nxt.own == OWN_CPU) && ctx_nxt.ram;

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_addr_o  <= '0;
      dram_ras_n_o <= 1'b1;
      dram_cas_n_o <= 1'b1;
      dram_we_n_o  <= 1'b1;
      ram_oe_o     <= 1'b0;
      cpu_grant_o  <= 1'b1;
      vid_grant_o  <= 1'b0;
    end else begin
      dram_addr_o  <= use_col ? addr_nxt[AW-1:ROW_W] : addr_nxt[ROW_W-1:0];
      dram_ras_n_o <= ~in_ras;
      dram_cas_n_o <= ~in_cas;
      dram_we_n_o  <= ~(in_cas && cpu_ram && !ctx_nxt.rd);
      ram_oe_o     <= in_cas && cpu_ram && ctx_nxt.rd;
      cpu_grant_o  <= (ctx_nxt.own == OWN_CPU);
      vid_grant_o  <= (ctx_nxt.own == OWN_VID);
    end
  end

  a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n_o |-> !dram_ras_n_o);

  a_r8_gate_read_only: assert property (@(posedge clk) disable iff (rst)
    ram_oe_o |-> (cpu_grant_o && dram_we_n_o && !dram_cas_n_o));

endmodule

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
  import dram_slot_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int DW       = 8,
  parameter int SLOT_LEN = 8,
  parameter int RAS_PH   = 1,
  parameter int COL_PH   = 2,
  parameter int CAS_PH   = 3,
  parameter int CAP_PH   = 5,
  parameter int PRE_PH   = 6,
  localparam int AW   = 2 * ROW_W,
  localparam int PH_W = $clog2(SLOT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_mode_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_ram_sel_i,
  input  logic [DW-1:0]    dram_dq_i,
  output logic [ROW_W-1:0] dram_addr_o,
  output logic             dram_ras_n_o,
  output logic             dram_cas_n_o,
  output logic             dram_we_n_o,
  output logic             ram_oe_o,
  output logic             cpu_grant_o,
  output logic             vid_grant_o,
  output logic [AW-1:0]    vid_addr_o,
  output logic [DW-1:0]    vid_data_o,
  output logic             vid_valid_o
);

  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            last;
  slot_ctx_t       ctx_q, ctx_nxt;
  logic [AW-1:0]   addr_nxt;
  logic            cap;

  dsa_phase_ctr #(.SLOT_LEN(SLOT_LEN)) phase_i (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nxt(ph_nxt), .last(last)
  );

  dsa_owner_sel #(.AW(AW)) owner_i (
    .clk(clk), .rst(rst), .last(last), .fast_mode_i(fast_mode_i),
    .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i),
    .cpu_ram_sel_i(cpu_ram_sel_i), .vid_addr_i(vid_addr_o),
    .ctx_q(ctx_q), .ctx_nxt(ctx_nxt), .addr_nxt(addr_nxt)
  );

  assign cap = (ph_q == PH_W'(CAP_PH)) && (ctx_q.own == OWN_VID);

  dsa_video_fetch #(.AW(AW), .DW(DW)) fetch_i (
    .clk(clk), .rst(rst), .cap(cap), .dq_i(dram_dq_i),
    .vid_addr_o(vid_addr_o), .vid_data_o(vid_data_o),
    .vid_valid_o(vid_valid_o)
  );

  dsa_strobe_drv #(
    .ROW_W(ROW_W), .PH_W(PH_W), .RAS_PH(RAS_PH), .COL_PH(COL_PH),
    .CAS_PH(CAS_PH), .PRE_PH(PRE_PH)
  ) strobe_i (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .ctx_nxt(ctx_nxt),
    .addr_nxt(addr_nxt), .dram_addr_o(dram_addr_o),
    .dram_ras_n_o(dram_ras_n_o), .dram_cas_n_o(dram_cas_n_o),
    .dram_we_n_o(dram_we_n_o), .ram_oe_o(ram_oe_o),
    .cpu_grant_o(cpu_grant_o), .vid_grant_o(vid_grant_o)
  );

  a_r1_ras_once: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n_o) |-> (ph_q == PH_W'(RAS_PH)));

  a_r9_valid_in_vid: assert property (@(posedge clk) disable iff (rst)
    vid_valid_o |-> vid_grant_o);

  a_r3_one_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot({cpu_grant_o, vid_grant_o}));

endmodule

// File: tb/dram_slot_arbiter_tb_top.sv
module dram_slot_arbiter_tb_top;

  localparam int ROW_W = 4;
  localparam int AW    = 2 * ROW_W;
  localparam int DW    = 8;
  localparam int NS    = 80;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fast_mode_i = 1'b0;
  logic [AW-1:0]    cpu_addr_i = '0;
  logic             cpu_rd_i = 1'b1;
  logic             cpu_ram_sel_i = 1'b0;
  logic [DW-1:0]    dram_dq_i;
  logic [ROW_W-1:0] dram_addr_o;
  logic             dram_ras_n_o, dram_cas_n_o, dram_we_n_o, ram_oe_o;
  logic             cpu_grant_o, vid_grant_o, vid_valid_o;
  logic [AW-1:0]    vid_addr_o;
  logic [DW-1:0]    vid_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_slot_arbiter dut_i (
    .clk(clk), .rst(rst), .fast_mode_i(fast_mode_i),
    .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i),
    .cpu_ram_sel_i(cpu_ram_sel_i), .dram_dq_i(dram_dq_i),
    .dram_addr_o(dram_addr_o), .dram_ras_n_o(dram_ras_n_o),
    .dram_cas_n_o(dram_cas_n_o), .dram_we_n_o(dram_we_n_o),
    .ram_oe_o(ram_oe_o), .cpu_grant_o(cpu_grant_o),
    .vid_grant_o(vid_grant_o), .vid_addr_o(vid_addr_o),
    .vid_data_o(vid_data_o), .vid_valid_o(vid_valid_o)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return DW'((int'(a) * 13 + 5) & 255);
  endfunction

  // memory model: row latched as RAS falls, data only while CAS is low
  logic [ROW_W-1:0] row_lat = '0;
  always @(negedge dram_ras_n_o) row_lat <= dram_addr_o;
  assign dram_dq_i = dram_cas_n_o ? '0 : mem_word({dram_addr_o, row_lat});

  function automatic bit plan_fast(input int s);
    return (s >= 30 && s < 50) || (s >= 60 && s < 63);
  endfunction
  function automatic logic [AW-1:0] plan_addr(input int s);
    return AW'((s * 37 + 11) & 255);
  endfunction
  function automatic bit plan_rd(input int s);
    return (s % 4) != 1;
  endfunction
  function automatic bit plan_ram(input int s);
    return (s % 3) != 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit            own_vid;
    logic [AW-1:0] ca, vcnt, vstart, a;
    bit            crd, cram;
    int            fast_vid_cycles;
    logic [AW-1:0] vid_before_fast;
    own_vid = 1'b0;
    vcnt = '0;
    vstart = '0;
    ca = '0; crd = 1'b1; cram = 1'b0;
    fast_vid_cycles = 0;
    vid_before_fast = '0;

    repeat (3) @(negedge clk);
    // R10: outputs while reset is held
    chk(dram_ras_n_o == 1'b1, "R10 ras_n in reset", dram_ras_n_o, 1);
    chk(dram_cas_n_o == 1'b1, "R10 cas_n in reset", dram_cas_n_o, 1);
    chk(cpu_grant_o == 1'b1,  "R10 cpu_grant in reset", cpu_grant_o, 1);
    chk(vid_grant_o == 1'b0,  "R10 vid_grant in reset", vid_grant_o, 0);
    chk(ram_oe_o == 1'b0,     "R10 ram_oe in reset", ram_oe_o, 0);
    chk(vid_addr_o == '0,     "R10 vid_addr in reset", vid_addr_o, 0);
    chk(vid_valid_o == 1'b0,  "R10 vid_valid in reset", vid_valid_o, 0);
    rst = 1'b0;

    for (int s = 0; s < NS; s++) begin
      if (s > 0) begin
        ca = plan_addr(s); crd = plan_rd(s); cram = plan_ram(s);
        own_vid = plan_fast(s) ? 1'b0 : !own_vid;   // R2 / R3 model
      end
      vstart = vcnt;
      if (s == 30) vid_before_fast = vid_addr_o;
      for (int j = 0; j < 8; j++) begin
        bit inr, inc, cpu_ram;
        inr = (j >= 1 && j <= 5);
        inc = (j >= 3 && j <= 5);
        a = own_vid ? vstart : ca;
        cpu_ram = !own_vid && cram;
        chk(dram_ras_n_o == !inr, cram || own_vid ? "R1 ras_n" : "R7 ras_n dummy",
            dram_ras_n_o, !inr);
        chk(dram_cas_n_o == !inc, cram || own_vid ? "R1 cas_n" : "R7 cas_n dummy",
            dram_cas_n_o, !inc);
        chk(dram_addr_o == ((j < 2) ? a[ROW_W-1:0] : a[AW-1:ROW_W]),
            own_vid ? "R4 R5 video row/col" : "R5 row/col",
            dram_addr_o, (j < 2) ? a[ROW_W-1:0] : a[AW-1:ROW_W]);
        chk(ram_oe_o == (cpu_ram && crd && inc), cram ? "R8 ram_oe" : "R7 ram_oe dummy",
            ram_oe_o, cpu_ram && crd && inc);
        chk(dram_we_n_o == !(cpu_ram && !crd && inc), cram ? "R8 we_n" : "R7 we_n dummy",
            dram_we_n_o, !(cpu_ram && !crd && inc));
        chk(cpu_grant_o == !own_vid, plan_fast(s) ? "R3 R6 cpu_grant" : "R2 R6 cpu_grant",
            cpu_grant_o, !own_vid);
        chk(vid_grant_o == own_vid, plan_fast(s) ? "R3 R6 vid_grant" : "R2 R6 vid_grant",
            vid_grant_o, own_vid);
        chk(vid_valid_o == (own_vid && j == 6), "R9 vid_valid", vid_valid_o, own_vid && j == 6);
        chk(vid_addr_o == ((own_vid && j >= 6) ? vstart + 1'b1 : vstart), "R9 R4 vid_addr",
            vid_addr_o, (own_vid && j >= 6) ? vstart + 1'b1 : vstart);
        if (own_vid && j == 6)
          chk(vid_data_o == mem_word(vstart), "R9 vid_data", vid_data_o, mem_word(vstart));
        if (plan_fast(s) && vid_grant_o) fast_vid_cycles++;
        // R6: wrong value early in the slot, real value later
        if (j == 1) fast_mode_i = !plan_fast(s + 1);
        if (j == 4) begin
          fast_mode_i   = plan_fast(s + 1);
          cpu_addr_i    = plan_addr(s + 1);
          cpu_rd_i      = plan_rd(s + 1);
          cpu_ram_sel_i = plan_ram(s + 1);
        end
        @(negedge clk);
      end
      if (own_vid) vcnt = vstart + 1'b1;
      if (s == 49)
        chk(vid_addr_o == vid_before_fast, "R4 no refresh in fast setting",
            vid_addr_o, vid_before_fast);
    end
    chk(fast_vid_cycles == 0, "R3 R4 video cycles in fast setting", fast_vid_cycles, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule